// File: doc/BRIEF.md
# Byte-Lane Read Parity Checker

This block checks the parity of a 64-bit read data word that is split into eight byte lanes. Each lane carries its own parity bit and has its own active-low lane select. A lane is checked only when its select is asserted. On each cycle where the read qualifier is high, the block samples the data, the parity bits and the lane selects. It reports the result one clock later on an active-low check flag and on a per-lane error vector. A separate active-low enable decides whether a detected error also raises a fault request for the rest of the chip to act on.

The same block also produces parity for outgoing write data. It does this combinationally, so that every lane of the write word carries even parity. Error correction, address parity and bus-cycle sequencing are not part of the block. The only timing it knows is the one-cycle read qualifier.

Top module: `lane_parity_check`

## Requirements
- R1: Lane i is data bits 8i+7 down to 8i. Its parity bit is bit i of the parity input, and its select is bit i of the active-low select input. Lane 0 is the least significant byte.
- R2: A selected lane is in error when its eight data bits plus its parity bit contain an odd number of ones (even parity).
- R3: For every lane i, the write-parity output bit i makes write byte i plus that bit hold an even number of ones. The output follows the write data in the same cycle.
- R4: A lane whose select is high never reports an error, whatever its data and parity. Its bit in the error vector is zero.
- R5: The check flag is low for exactly the one cycle after a qualified sample with at least one selected bad lane. In that same cycle, the error vector holds a 1 for each such lane and 0 for every other lane.
- R6: After a cycle with the read qualifier low, or with no lane selected, the flag is high and the error vector is zero.
- R7: The fault output is high in the cycle after a qualified sample only when that sample had a selected bad lane and the check enable was low. A high check enable leaves the flag and the error vector unchanged but keeps the fault output low.
- R8: While reset is low, the flag is high, the error vector is zero and the fault output is low.
- R9: Several bad lanes in one sample are all reported together in the error vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_data | input | 64 | Read data word |
| rd_par | input | 8 | Read parity, one bit per lane |
| rd_be_n | input | 8 | Active-low lane selects |
| rd_valid | input | 1 | Read sample qualifier |
| chk_en_n | input | 1 | Active-low check enable for fault reporting |
| wr_data | input | 64 | Write data word |
| wr_par | output | 8 | Generated even parity for write data |
| perr_n | output | 1 | Active-low parity check flag, registered |
| lane_err | output | 8 | Per-lane error vector, registered |
| par_fault | output | 1 | Fault request, registered |

## Verification
The assertions assume that the read inputs are sampled only on clock edges, so a read result always refers to the previous cycle's inputs. They also assume that reset is held for at least one edge before any read is issued. The stimulus respects this: it changes every input only on the falling edge and keeps the read qualifier low throughout reset. Runs of reads with and without the qualifier are placed back to back, so the one-cycle shape of the flag is seen next to idle cycles.

// File: rtl/lane_par_pkg.sv
package lane_par_pkg;
  localparam int LANES_DEF  = 8;
  localparam int LANE_W_DEF = 8;

  // fill bit that makes a lane hold an even count of ones
  function automatic logic even_fill(input logic [LANE_W_DEF-1:0] lane);
    return ^lane;
  endfunction

  // lane is bad when data and its parity bit together carry an odd count
  function automatic logic lane_mismatch(input logic [LANE_W_DEF-1:0] lane,
                                         input logic pbit);
    return (^lane) ^ pbit;
  endfunction
endpackage

// File: rtl/lane_par_gen.sv
module lane_par_gen #(
  parameter int LANES  = lane_par_pkg::LANES_DEF,
  parameter int LANE_W = lane_par_pkg::LANE_W_DEF,
  localparam int DW    = LANES * LANE_W
) (
  input  logic [DW-1:0]    data,
  output logic [LANES-1:0] fill
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign fill[g] = lane_par_pkg::even_fill(data[g*LANE_W +: LANE_W]);
  end
endmodule

// File: rtl/lane_par_eval.sv
module lane_par_eval #(
  parameter int LANES = lane_par_pkg::LANES_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] data_fill,
  input  logic [LANES-1:0] par_in,
  input  logic [LANES-1:0] sel_n,
  input  logic             sample,
  input  logic             act_en_n,
  output logic [LANES-1:0] lane_bad,
  output logic             hit,
  output logic             perr_n,
  output logic [LANES-1:0] lane_err,
  output logic             fault
);
  logic [LANES-1:0] mism;

  for (genvar g = 0; g < LANES; g++) begin : g_cmp
    assign mism[g]     = data_fill[g] ^ par_in[g];
    assign lane_bad[g] = mism[g] & ~sel_n[g];
  end

  assign hit = sample & (|lane_bad);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      perr_n   <= 1'b1;
      lane_err <= '0;
      fault    <= 1'b0;
    end else begin
      perr_n   <= ~hit;
      lane_err <= sample ? lane_bad : '0;
      fault    <= hit & ~act_en_n;
    end
  end
endmodule

// File: rtl/lane_parity_check.sv
module lane_parity_check #(
  parameter int LANES  = lane_par_pkg::LANES_DEF,
  parameter int LANE_W = lane_par_pkg::LANE_W_DEF,
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DW-1:0]    rd_data,
  input  logic [LANES-1:0] rd_par,
  input  logic [LANES-1:0] rd_be_n,
  input  logic             rd_valid,
  input  logic             chk_en_n,
  input  logic [DW-1:0]    wr_data,
  output logic [LANES-1:0] wr_par,
  output logic             perr_n,
  output logic [LANES-1:0] lane_err,
  output logic             par_fault
);
  logic [LANES-1:0] rd_fill;
  logic [LANES-1:0] lane_bad;
  logic             hit;

  lane_par_gen #(.LANES(LANES), .LANE_W(LANE_W)) u_rd_gen (
    .data (rd_data),
    .fill (rd_fill)
  );

  lane_par_gen #(.LANES(LANES), .LANE_W(LANE_W)) u_wr_gen (
    .data (wr_data),
    .fill (wr_par)
  );

  lane_par_eval #(.LANES(LANES)) u_eval (
    .clk       (clk),
    .rst_n     (rst_n),
    .data_fill (rd_fill),
    .par_in    (rd_par),
    .sel_n     (rd_be_n),
    .sample    (rd_valid),
    .act_en_n  (chk_en_n),
    .lane_bad  (lane_bad),
    .hit       (hit),
    .perr_n    (perr_n),
    .lane_err  (lane_err),
    .fault     (par_fault)
  );
endmodule

// File: rtl/lane_parity_check_sva.sv
module lane_parity_check_sva #(
  parameter int LANES  = 8,
  parameter int LANE_W = 8,
  localparam int DW    = LANES * LANE_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LANES-1:0] rd_be_n,
  input logic             rd_valid,
  input logic             chk_en_n,
  input logic [DW-1:0]    wr_data,
  input logic [LANES-1:0] wr_par,
  input logic             perr_n,
  input logic [LANES-1:0] lane_err,
  input logic             par_fault,
  input logic             hit
);
  // counts ones per lane including its parity bit; every count must be even
  function automatic logic all_even(input logic [DW-1:0] d, input logic [LANES-1:0] p);
    logic ok;
    ok = 1'b1;
    for (int l = 0; l < LANES; l++) begin
      int n;
      n = int'(p[l]);
      for (int b = 0; b < LANE_W; b++) n += int'(d[l*LANE_W + b]);
      if (n % 2 != 0) ok = 1'b0;
    end
    return ok;
  endfunction

  a_r3_write_even: assert property (@(posedge clk) disable iff (!rst_n)
    all_even(wr_data, wr_par));

  a_r4_masked_lanes_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_err & $past(rd_be_n)) == '0);

  a_r5_flag_tracks_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (!perr_n) == (lane_err != '0));

  a_r5_flag_after_hit: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !perr_n);

  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> (perr_n && lane_err == '0));

  a_r7_fault_gated: assert property (@(posedge clk) disable iff (!rst_n)
    par_fault |-> (!perr_n && !$past(chk_en_n)));
endmodule

bind lane_parity_check lane_parity_check_sva #(.LANES(LANES), .LANE_W(LANE_W)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_be_n   (rd_be_n),
  .rd_valid  (rd_valid),
  .chk_en_n  (chk_en_n),
  .wr_data   (wr_data),
  .wr_par    (wr_par),
  .perr_n    (perr_n),
  .lane_err  (lane_err),
  .par_fault (par_fault),
  .hit       (hit)
);

// File: tb/lane_parity_check_test.sv
module lane_parity_check_test;
  timeunit 1ns; timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] rd_data = '0;
  logic [7:0]  rd_par = '0;
  logic [7:0]  rd_be_n = 8'hFF;
  logic        rd_valid = 1'b0;
  logic        chk_en_n = 1'b0;
  logic [63:0] wr_data = '0;
  logic [7:0]  wr_par;
  logic        perr_n;
  logic [7:0]  lane_err;
  logic        par_fault;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct {
    logic       f_n;
    logic [7:0] err;
    logic       flt;
    string      req;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  lane_parity_check uut (
    .clk(clk), .rst_n(rst_n), .rd_data(rd_data), .rd_par(rd_par),
    .rd_be_n(rd_be_n), .rd_valid(rd_valid), .chk_en_n(chk_en_n),
    .wr_data(wr_data), .wr_par(wr_par), .perr_n(perr_n),
    .lane_err(lane_err), .par_fault(par_fault)
  );

  // parity bit that makes a byte's ones count even, by counting
  function automatic logic fill_of(input logic [7:0] b);
    int n = 0;
    for (int k = 0; k < 8; k++) if (b[k]) n++;
    return (n % 2) == 1;
  endfunction

  function automatic logic [7:0] good_par(input logic [63:0] d);
    logic [7:0] p;
    for (int l = 0; l < 8; l++) p[l] = fill_of(d[8*l +: 8]);
    return p;
  endfunction

  task automatic rd(input logic [63:0] d, input logic [7:0] p, input logic [7:0] be,
                    input logic v, input logic en, input string req);
    exp_t e;
    logic [7:0] bl;
    @(negedge clk);
    rd_data = d; rd_par = p; rd_be_n = be; rd_valid = v; chk_en_n = en;
    for (int l = 0; l < 8; l++) bl[l] = !be[l] && (fill_of(d[8*l +: 8]) != p[l]);
    e.f_n = !(v && (bl != 0));
    e.err = v ? bl : 8'h00;
    e.flt = v && (bl != 0) && !en;
    e.req = req;
    q.push_back(e);
  endtask

  task automatic wr_chk(input logic [63:0] d);
    logic [7:0] e;
    @(negedge clk);
    wr_data = d;
    #1;
    e = good_par(d);
    total++;
    if (wr_par !== e) begin
      bad++;
      $display("FAIL R3 wr_par actual=%h expected=%h", wr_par, e);
    end
  endtask

  // monitor: compare each registered result one step after the edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      total++;
      if (perr_n !== e.f_n || lane_err !== e.err || par_fault !== e.flt) begin
        bad++;
        $display("FAIL %s actual flag=%b err=%h fault=%b expected flag=%b err=%h fault=%b",
                 e.req, perr_n, lane_err, par_fault, e.f_n, e.err, e.flt);
      end
    end
  end

  initial begin
    #(5ns * 100000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    repeat (3) @(negedge clk);
    total++;
    if (perr_n !== 1'b1 || lane_err !== 8'h00 || par_fault !== 1'b0) begin
      bad++;
      $display("FAIL R8 reset actual flag=%b err=%h fault=%b expected 1 00 0",
               perr_n, lane_err, par_fault);
    end
    @(negedge clk); rst_n = 1'b1;

    d = 64'h0123_4567_89AB_CDEF;
    rd(d, good_par(d), 8'h00, 1, 0, "R2 all lanes good");
    rd(d, good_par(d) ^ 8'h01, 8'h00, 1, 0, "R1 lane0 bad");
    rd(d, good_par(d) ^ 8'h80, 8'h00, 1, 0, "R1 lane7 bad");
    rd(d, good_par(d), 8'h00, 0, 0, "R5 one-cycle flag then idle");
    rd(d ^ 64'h0000_0000_0010_0000, good_par(d), 8'h00, 1, 0, "R2 data bit flip lane2");
    rd(d, good_par(d) ^ 8'h10, 8'h10, 1, 0, "R4 bad lane4 masked");
    rd(d, good_par(d) ^ 8'hFF, 8'hA5, 1, 0, "R4 mixed masks");
    rd(d, good_par(d) ^ 8'h5A, 8'h00, 1, 0, "R9 several bad lanes");
    rd(d, good_par(d) ^ 8'hFF, 8'hFF, 1, 0, "R6 no lane selected");
    rd(d, good_par(d) ^ 8'hFF, 8'h00, 0, 0, "R6 no qualifier");
    rd(d, good_par(d) ^ 8'h08, 8'h00, 1, 1, "R7 enable high no fault");
    rd(d, good_par(d) ^ 8'h08, 8'h00, 1, 0, "R7 enable low fault");
    rd(64'hFFFF_FFFF_FFFF_FFFF, 8'h00, 8'h00, 1, 0, "R2 all ones good");
    rd(64'hFFFF_FFFF_FFFF_FFFF, 8'h00, 8'h7E, 1, 1, "R5 back-to-back masked good");
    rd(64'h8000_0000_0000_0001, 8'h80, 8'h00, 1, 0, "R1 odd bytes lane0 bad");
    rd(64'h0, 8'h0, 8'hFF, 0, 1, "R6 drain");
    wait (q.size() == 0);

    wr_chk(64'h0);
    wr_chk(64'hFFFF_FFFF_FFFF_FFFF);
    wr_chk(64'h0123_4567_89AB_CDEF);
    wr_chk(64'h8001_0307_0F1F_3F7F);

    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule